// File: doc/BRIEF.md
# Latency-Pair Issue Interlock

This block sits at the issue stage of a single-thread, single-issue, in-order pipeline and decides whether the instruction on offer may leave this cycle. For each architectural destination register it remembers which operation class last wrote it and how many cycles have passed since that writer issued. A new instruction is held back until every enabled source has aged past the delay that applies to the pair formed by the writer's class and the reader's class. The required delay is a property of that pair, not only of the writer: an integer result feeding a load address, for example, needs more time than the same result feeding another integer operation.

The block also tracks five execution resources: integer, load/store, branch, vector arithmetic and vector move. Non-pipelined operations claim all five for their whole duration. The barrier-type load/store operations hold the load/store resource alone. Register values and results are not handled here.

The issue request is a valid/ready stream. `iss_ready` is a combinational function of the offered request and the internal state. An instruction issues on a rising edge where both `iss_valid` and `iss_ready` are high. While `iss_ready` is low, the source keeps the request stable and re-offers it every cycle. The first cycle in which all sources and the needed resources are free produces the grant.

Top module: `sb_interlock`

## Requirements
- R1: Issue occurs on a clock edge with `iss_valid` and `iss_ready` both high. After reset no register is pending and `units_busy` is 0, so any request is ready at once. Class codes are: 0 integer, 1 two-part integer, 2 three-part integer, 3 load, 4 FP arithmetic, 5 FP compare, 6 vector simple, 7 vector permute, 8 vector complex, 9 vector float, 10 move to count/link, 11 direct branch, 12 register-indirect branch, 13 CR logic, 14 load/store barrier, 15 32-bit divide, 16 64-bit divide, 17 64-bit multiply, 18 32-bit multiply, 19 FP divide, 20 square root, 21 CR read. Codes 22 to 31 act as code 0.
- R2: Outside the pairs named in R3 to R6, a consumer that issues k cycles after its producer (k = 1 for back-to-back) needs k to be at least the producer latency. The latencies are: integer 2, two-part 4, three-part 6, load 2, FP arithmetic 10, FP compare 1, vector simple 4, vector permute 4, vector complex 10, vector float 12, move to count/link 1, branches and CR logic 1, barrier 11, and for codes 15 to 21 in order: 32, 64, 15, 9, 74, 84, 34.
- R3: A load consuming an integer result, or a load consuming a load result, needs a delay of 5.
- R4: A direct branch, indirect branch, CR logic or CR read consuming an FP compare result needs a delay of 6.
- R5: Vector float to vector float needs 11. Vector complex to vector simple needs 6. Vector float to vector complex needs 3.
- R6: Move to count/link followed by a register-indirect branch needs 10.
- R7: A class 15 to 21 operation issued at cycle t sets all five `units_busy` bits and blocks every class until cycle t+N, where N is its latency.
- R8: A barrier (class 14) issued at cycle t holds the load/store bit (`units_busy[1]`) until t+11. During that time loads and barriers stall, and other classes do not.
- R9: A later writer of a register replaces the earlier writer's class and age. Register 0 is tracked like every other register.
- R10: A source whose enable is low never stalls. An issue with `dst_en` low records nothing.
- R11: A request offered with `iss_valid` low changes no state.
- R12: Bit positions of `units_busy`: 0 integer, 1 load/store, 2 branch, 3 vector arithmetic, 4 vector move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Request may issue this cycle |
| iss_class | input | 5 | Operation class code |
| src_a_en | input | 1 | First source used |
| src_a | input | REG_W | First source register |
| src_b_en | input | 1 | Second source used |
| src_b | input | REG_W | Second source register |
| dst_en | input | 1 | Destination written |
| dst | input | REG_W | Destination register |
| units_busy | output | 5 | Resources held by long operations |

## Verification
The bench measures the number of stall cycles for each producer/consumer pair and compares it with the pair delay. It includes pairs where the same producer gives different delays to different consumers. A design that applied only the producer latency would show a short wait for integer-to-load and a long wait for vector float to vector complex. A design with an off-by-one age would miss every count by one. Further tests cover:
- register overwrite by a shorter-latency producer, where a design that kept the older age would over-stall;
- register 0, which a design might treat as always ready;
- disabled sources and destinations;
- the barrier blocking only load/store users;
- non-pipelined holds, where a design that released early would grant after 31 cycles instead of 32.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [4:0] {
    OC_INT      = 5'd0,
    OC_INT2     = 5'd1,
    OC_INT3     = 5'd2,
    OC_LOAD     = 5'd3,
    OC_FPU      = 5'd4,
    OC_FCMP     = 5'd5,
    OC_VSIMPLE  = 5'd6,
    OC_VPERM    = 5'd7,
    OC_VCPLX    = 5'd8,
    OC_VFLT     = 5'd9,
    OC_SPRMOVE  = 5'd10,
    OC_BR       = 5'd11,
    OC_BRIND    = 5'd12,
    OC_CRLOGIC  = 5'd13,
    OC_BARRIER  = 5'd14,
    OC_DIV32    = 5'd15,
    OC_DIV64    = 5'd16,
    OC_MUL64    = 5'd17,
    OC_MUL32    = 5'd18,
    OC_FDIV     = 5'd19,
    OC_FSQRT    = 5'd20,
    OC_CRREAD   = 5'd21
  } op_class_t;

  localparam int NUM_UNITS = 5;
  localparam int U_FX = 0;
  localparam int U_LS = 1;
  localparam int U_BR = 2;
  localparam int U_VA = 3;
  localparam int U_VM = 4;

  function automatic op_class_t norm_class(input logic [4:0] code);
    return (code > 5'd21) ? OC_INT : op_class_t'(code);
  endfunction

  function automatic int unsigned base_latency(input op_class_t c);
    case (c)
      OC_INT, OC_LOAD:                 return 2;
      OC_INT2, OC_VSIMPLE, OC_VPERM:   return 4;
      OC_INT3:                         return 6;
      OC_FPU, OC_VCPLX:                return 10;
      OC_VFLT:                         return 12;
      OC_BARRIER:                      return 11;
      OC_DIV32:                        return 32;
      OC_DIV64:                        return 64;
      OC_MUL64:                        return 15;
      OC_MUL32:                        return 9;
      OC_FDIV:                         return 74;
      OC_FSQRT:                        return 84;
      OC_CRREAD:                       return 34;
      default:                         return 1;
    endcase
  endfunction

  // Delay from producer issue to consumer issue for a given pair.
  function automatic int unsigned pair_delay(input op_class_t p, input op_class_t c);
    if ((p == OC_INT || p == OC_LOAD) && c == OC_LOAD) return 5;
    if (p == OC_FCMP && (c == OC_BR || c == OC_BRIND || c == OC_CRLOGIC || c == OC_CRREAD))
      return 6;
    if (p == OC_VFLT && c == OC_VFLT) return 11;
    if (p == OC_VCPLX && c == OC_VSIMPLE) return 6;
    if (p == OC_VFLT && c == OC_VCPLX) return 3;
    if (p == OC_SPRMOVE && c == OC_BRIND) return 10;
    return base_latency(p);
  endfunction

  function automatic logic is_nonpipe(input op_class_t c);
    return (c >= OC_DIV32) && (c <= OC_CRREAD);
  endfunction

  function automatic logic [NUM_UNITS-1:0] unit_need(input op_class_t c);
    logic [NUM_UNITS-1:0] m;
    m = '0;
    if (is_nonpipe(c)) m = '1;
    else begin
      case (c)
        OC_LOAD, OC_BARRIER:                             m[U_LS] = 1'b1;
        OC_FPU, OC_FCMP, OC_VSIMPLE, OC_VCPLX, OC_VFLT:  m[U_VA] = 1'b1;
        OC_VPERM:                                        m[U_VM] = 1'b1;
        OC_SPRMOVE, OC_BR, OC_BRIND, OC_CRLOGIC:         m[U_BR] = 1'b1;
        default:                                         m[U_FX] = 1'b1;
      endcase
    end
    return m;
  endfunction

  // Cycles a claimed unit stays held, counting the issue cycle.
  function automatic int unsigned unit_hold(input op_class_t c);
    if (is_nonpipe(c)) return base_latency(c);
    if (c == OC_BARRIER) return 11;
    return 1;
  endfunction

endpackage

// File: rtl/sb_table.sv
module sb_table
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int AGE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_idx,
  input  op_class_t        rd_cls,
  input  logic             rd_a_en,
  input  logic [REG_W-1:0] rd_a,
  input  logic             rd_b_en,
  input  logic [REG_W-1:0] rd_b,
  output logic             srcs_ok
);
  localparam int NUM_REGS = 1 << REG_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q [NUM_REGS];
  op_class_t        cls_q [NUM_REGS];
  logic [NUM_REGS-1:0] live_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          live_q[gi] <= 1'b0;
          age_q[gi]  <= '0;
          cls_q[gi]  <= OC_INT;
        end else if (wr_en && wr_idx == REG_W'(gi)) begin
          live_q[gi] <= 1'b1;
          age_q[gi]  <= AGE_W'(1);
          cls_q[gi]  <= rd_cls;
        end else if (live_q[gi] && age_q[gi] != AGE_MAX) begin
          age_q[gi] <= age_q[gi] + AGE_W'(1);
        end
      end
    end
  endgenerate

  function automatic logic src_ready(input logic en, input logic [REG_W-1:0] idx,
                                     input op_class_t c);
    if (!en || !live_q[idx]) return 1'b1;
    return int'(age_q[idx]) >= int'(pair_delay(cls_q[idx], c));
  endfunction

  always_comb begin
    srcs_ok = src_ready(rd_a_en, rd_a, rd_cls) && src_ready(rd_b_en, rd_b, rd_cls);
  end
endmodule

// File: rtl/sb_units.sv
module sb_units
  import sb_pkg::*;
#(
  parameter int HOLD_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  op_class_t            cls,
  output logic                 units_ok,
  output logic [NUM_UNITS-1:0] busy
);
  logic [NUM_UNITS-1:0] need;
  logic [HOLD_W-1:0]    hold_m1;

  always_comb begin
    need     = unit_need(cls);
    hold_m1  = HOLD_W'(unit_hold(cls) - 1);
    units_ok = (need & busy) == '0;
  end

  genvar gu;
  generate
    for (gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
      logic [HOLD_W-1:0] left_q;
      always_ff @(posedge clk) begin
        if (rst)                    left_q <= '0;
        else if (take && need[gu])  left_q <= hold_m1;
        else if (left_q != '0)      left_q <= left_q - HOLD_W'(1);
      end
      assign busy[gu] = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/sb_interlock.sv
module sb_interlock
  import sb_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int AGE_W  = 7,
  parameter int HOLD_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [4:0]       iss_class,
  input  logic             src_a_en,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_b_en,
  input  logic [REG_W-1:0] src_b,
  input  logic             dst_en,
  input  logic [REG_W-1:0] dst,
  output logic [4:0]       units_busy
);
  op_class_t cls;
  logic      srcs_ok;
  logic      units_ok;
  logic      fire;

  assign cls       = norm_class(iss_class);
  assign iss_ready = srcs_ok && units_ok;
  assign fire      = iss_valid && iss_ready;

  sb_table #(.REG_W(REG_W), .AGE_W(AGE_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fire && dst_en),
    .wr_idx  (dst),
    .rd_cls  (cls),
    .rd_a_en (src_a_en),
    .rd_a    (src_a),
    .rd_b_en (src_b_en),
    .rd_b    (src_b),
    .srcs_ok (srcs_ok)
  );

  sb_units #(.HOLD_W(HOLD_W)) u_units (
    .clk      (clk),
    .rst      (rst),
    .take     (fire),
    .cls      (cls),
    .units_ok (units_ok),
    .busy     (units_busy)
  );
endmodule

// File: rtl/sb_interlock_chk.sv
module sb_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [4:0]       iss_class,
  input logic             src_a_en,
  input logic [REG_W-1:0] src_a,
  input logic             src_b_en,
  input logic [REG_W-1:0] src_b,
  input logic             dst_en,
  input logic [REG_W-1:0] dst,
  input logic [4:0]       units_busy
);
  logic fire;
  assign fire = iss_valid && iss_ready;

  // R2: an integer consumer cannot issue back-to-back on an integer result
  assert_int_chain_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && dst_en && iss_class == 5'd0) |=>
      !(fire && src_a_en && src_a == $past(dst) && iss_class == 5'd0));

  assert_nonpipe_claims_all_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && iss_class >= 5'd15 && iss_class <= 5'd21) |=> (units_busy == 5'h1F));

  assert_all_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (units_busy == 5'h1F) |-> !iss_ready);

  assert_barrier_holds_lsu_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && iss_class == 5'd14) |=> units_busy[1]);

  assert_load_waits_lsu_R8: assert property (@(posedge clk) disable iff (rst)
    (units_busy[1] && iss_class == 5'd3) |-> !iss_ready);
endmodule

bind sb_interlock sb_interlock_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/sb_interlock_test.sv
module sb_interlock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_valid = 1'b0;
  logic       iss_ready;
  logic [4:0] iss_class = '0;
  logic       src_a_en = 1'b0;
  logic [4:0] src_a = '0;
  logic       src_b_en = 1'b0;
  logic [4:0] src_b = '0;
  logic       dst_en = 1'b0;
  logic [4:0] dst = '0;
  logic [4:0] units_busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sb_interlock uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Called just after a falling edge. Returns stall cycles before the grant.
  task automatic send(input int cls, input bit ae, input int a, input bit be, input int b,
                      input bit de, input int d, output int waited);
    iss_class = 5'(cls); src_a_en = ae; src_a = 5'(a); src_b_en = be; src_b = 5'(b);
    dst_en = de; dst = 5'(d); iss_valid = 1'b1;
    waited = 0;
    #1;
    while (!iss_ready && waited < 300) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0; src_a_en = 1'b0; src_b_en = 1'b0; dst_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Producer (class p) writes reg r, consumer (class c) reads it next.
  task automatic pair(input string req, input int p, input int c, input int exp_wait);
    int w;
    idle(100);
    send(p, 0, 0, 0, 0, 1, 7, w);
    send(c, 1, 7, 0, 0, 0, 0, w);
    check(w == exp_wait, req, w, exp_wait);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(units_busy == 5'd0, "R1 busy after reset", units_busy, 0);
    iss_valid = 1'b1; iss_class = 5'd3; src_a_en = 1'b1; src_a = 5'd4; #1;
    check(iss_ready == 1'b1, "R1 ready after reset", iss_ready, 1);
    iss_valid = 1'b0; src_a_en = 1'b0;
  endtask

  task automatic t_defaults();
    pair("R2 int->int", 0, 0, 1);
    pair("R2 int3->int", 2, 0, 5);
    pair("R2 fpu->fpu", 4, 4, 9);
    pair("R2 load->int", 3, 0, 1);
    pair("R1 code 25 acts as int", 25, 0, 1);
  endtask

  task automatic t_int_load();
    pair("R3 int->load", 0, 3, 4);
    pair("R3 load->load", 3, 3, 4);
  endtask

  task automatic t_fcmp();
    pair("R4 fcmp->branch", 5, 11, 5);
    pair("R4 fcmp->crlogic", 5, 13, 5);
    pair("R4 fcmp->int", 5, 0, 0);
  endtask

  task automatic t_vector();
    pair("R5 vflt->vflt", 9, 9, 10);
    pair("R5 vflt->vsimple", 9, 6, 11);
    pair("R5 vcplx->vsimple", 8, 6, 5);
    pair("R5 vflt->vcplx", 9, 8, 2);
  endtask

  task automatic t_spr();
    pair("R6 sprmove->indirect", 10, 12, 9);
    pair("R6 sprmove->direct", 10, 11, 0);
  endtask

  task automatic t_nonpipe();
    int w;
    idle(100);
    send(15, 0, 0, 0, 0, 1, 9, w);
    check(units_busy == 5'h1F, "R7 R12 all units busy", units_busy, 31);
    send(0, 0, 0, 0, 0, 0, 0, w);
    check(w == 31, "R7 div32 blocks independent int", w, 31);
    idle(100);
    send(20, 0, 0, 0, 0, 0, 0, w);
    send(11, 0, 0, 0, 0, 0, 0, w);
    check(w == 83, "R7 sqrt blocks branch", w, 83);
  endtask

  task automatic t_barrier();
    int w;
    idle(100);
    send(14, 0, 0, 0, 0, 0, 0, w);
    check(units_busy == 5'b00010, "R8 R12 only lsu busy", units_busy, 2);
    send(0, 0, 0, 0, 0, 0, 0, w);
    check(w == 0, "R8 int not blocked", w, 0);
    send(3, 0, 0, 0, 0, 0, 0, w);
    check(w == 9, "R8 load waits for barrier", w, 9);
  endtask

  task automatic t_overwrite();
    int w;
    idle(100);
    send(9, 0, 0, 0, 0, 1, 5, w);
    send(0, 0, 0, 0, 0, 1, 5, w);
    send(0, 1, 5, 0, 0, 0, 0, w);
    check(w == 1, "R9 newer writer replaces older", w, 1);
    pair("R9 reg0 placeholder", 0, 0, 1);
    idle(100);
    send(2, 0, 0, 0, 0, 1, 0, w);
    send(0, 0, 0, 1, 0, 0, 0, w);
    check(w == 5, "R9 register 0 tracked", w, 5);
  endtask

  task automatic t_enables();
    int w;
    idle(100);
    send(9, 0, 0, 0, 0, 1, 6, w);
    send(9, 0, 6, 0, 6, 0, 0, w);
    check(w == 0, "R10 disabled sources ignored", w, 0);
    idle(100);
    send(9, 0, 0, 0, 0, 0, 8, w);
    send(9, 1, 8, 0, 0, 0, 0, w);
    check(w == 0, "R10 dst_en low records nothing", w, 0);
  endtask

  task automatic t_novalid();
    int w;
    idle(100);
    iss_valid = 1'b0; iss_class = 5'd15; dst_en = 1'b1; dst = 5'd12;
    idle(3);
    check(units_busy == 5'd0, "R11 no claim without valid", units_busy, 0);
    send(0, 1, 12, 0, 0, 0, 0, w);
    check(w == 0, "R11 no record without valid", w, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_defaults();
    t_int_load();
    t_fcmp();
    t_vector();
    t_spr();
    t_nonpipe();
    t_barrier();
    t_overwrite();
    t_enables();
    t_novalid();
    idle(5);
    finish_run();
  end
endmodule